// File: doc/BRIEF.md
# Delay Compensation Cell Ring Controller

This block looks after one link's ring of fixed-size cell slots in external memory. The ring absorbs the delay differences between the links of a group. Software supplies four configuration values:

- a 12-bit region base;
- a start pointer and an end pointer, both in 16-byte units;
- a frame-length selector that gives M, the number of cells per frame.

The block checks this configuration without pause. When the check fails, it raises an error flag. It also drives out the ring length in bytes, so that group-level logic can compare the ring sizes of all links in a group.

A start request is accepted only when the configuration is clean. When accepted, the block first writes zeros over the whole ring region, one 32-bit word per accepted memory cycle. It then pulses a completion flag and brings the link up.

From that point on, received cells arrive as a stream of 13 32-bit words. Each cell goes into the next 64-byte slot. Three trailer words follow the cell: a valid bit with a slot sequence number, then two zero words. The slot pointer wraps back to the start of the ring when the next slot would reach the end pointer. The byte address of the newest complete slot is exported for the reader side.

Top module: `cellring_buf_ctrl`

## Requirements
- R1: Every memory byte address is formed as follows: the region base in bits 31..20, a 16-bit pointer in bits 19..4, and zeros in bits 3..0. The pointer is the start pointer, or the current pointer derived from it.
- R2: `cfg_err` is 1 when the ring length in 16-byte units (end − start) is not a multiple of 4·M. That is the same as a byte length that is not a multiple of M·64.
- R3: `cfg_err` is 1 when the start pointer is not a multiple of 4·M. That is the same as a start byte address that is not aligned to M·64.
- R4: `cfg_err` is 1 when the ring length is below 8·M units (2·M·64 bytes). An end pointer at or below the start pointer counts as length zero.
- R5: `len_bytes` equals (end − start)·16 when end > start, and 0 otherwise.
- R6: A `start_req` seen while `cfg_err` is 1 is ignored. `link_up` stays 0 and no memory write is requested.
- R7: After an accepted start, the block writes data 0 to every word address of the ring, in ascending order from the start address up to the end address − 4. A word is written only in cycles with `mem_ready` = 1, and the address holds while `mem_ready` = 0.
- R8: `fill_done` is 1 for exactly one cycle, in the cycle after the last zero word is accepted. `link_up` goes to 1 in that same cycle. `cell_ready` stays 0 while the link is down.
- R9: Cell word k (k = 0..12) is written at slot address + 4k with the `cell_data` value. `cell_ready` = 1 exactly when the link is up, the slot is in its cell part, and `mem_ready` = 1.
- R10: Words 13 to 15 of a slot need no input, and `cell_ready` is 0 during them. Word 13 carries {1'b1, 15'b0, seq[15:0]}, and words 14 and 15 carry 0. The sequence number starts at 0 and rises by 1 for each slot.
- R11: The first slot is at the start pointer. Each later slot lies 64 bytes (4 pointer units) further on. When the next slot pointer would be at or beyond the end pointer, it returns to the start pointer.
- R12: In the cycle after word 15 of a slot is accepted, `newest_slot_addr` shows that slot's byte address and `newest_valid` is 1. Both read 0 after reset.
- R13: `cfg_frame_sel` encodes M as follows: 0 = 32, 1 = 64, 2 = 128, 3 = 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | 12 | Region base, upper address bits |
| cfg_start_ptr | input | 16 | Ring start pointer, 16-byte units |
| cfg_end_ptr | input | 16 | Ring end pointer, 16-byte units |
| cfg_frame_sel | input | 2 | Frame-length selector (M) |
| start_req | input | 1 | Request to zero-fill and bring the link up |
| cfg_err | output | 1 | Configuration error flag |
| len_bytes | output | 20 | Ring length in bytes, for group comparison |
| fill_done | output | 1 | One-cycle pulse when the zero-fill ends |
| link_up | output | 1 | Ring is ready for cells |
| cell_valid | input | 1 | Cell word present |
| cell_data | input | 32 | Cell word |
| cell_ready | output | 1 | Cell word accepted this cycle |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| newest_slot_addr | output | 32 | Byte address of the newest complete slot |
| newest_valid | output | 1 | At least one slot has been completed |

## Verification
The bench builds the block with its default 12/16/4-bit address split.

It drives all four frame-length codes through the configuration checker. This shows the M = 256 limits rejecting a ring that the M = 64 and M = 128 limits accept.

For the live run it uses M = 32 with the smallest legal ring, 256 units or 64 slots. At that size the complete zero-fill of 1024 words can be checked word by word. The same run also reaches the ring wrap after the 64th cell and confirms that the 65th cell returns to the start slot.

// File: rtl/cellring_pkg.sv
package cellring_pkg;
    localparam int BASE_W     = 12;
    localparam int PTR_W      = 16;
    localparam int LOW_W      = 4;
    localparam int ADDR_W     = BASE_W + PTR_W + LOW_W;
    localparam int DATA_W     = 32;
    localparam int SLOT_WORDS = 16;
    localparam int CELL_WORDS = 13;
    localparam int WIDX_W     = $clog2(SLOT_WORDS);
    localparam int SEQ_W      = 16;
    localparam int LEN_W      = PTR_W + LOW_W;
    localparam int SLOT_UNITS = (SLOT_WORDS * DATA_W / 8) >> LOW_W;

    typedef enum logic [1:0] {
        LNK_IDLE,
        LNK_FILL,
        LNK_RUN
    } lnk_state_e;

    typedef struct packed {
        logic              req;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } mem_wr_t;

    // Frame length M expressed in 16-byte units (M * 64 / 16)
    function automatic logic [PTR_W-1:0] frame_units(input logic [1:0] sel);
        logic [PTR_W-1:0] u;
        case (sel)
            2'd0:    u = PTR_W'(128);
            2'd1:    u = PTR_W'(256);
            2'd2:    u = PTR_W'(512);
            default: u = PTR_W'(1024);
        endcase
        return u;
    endfunction

    function automatic logic [ADDR_W-1:0] byte_addr(input logic [BASE_W-1:0] base,
                                                    input logic [PTR_W-1:0]  ptr);
        return {base, ptr, {LOW_W{1'b0}}};
    endfunction
endpackage

// File: rtl/cellring_cfg_check.sv
module cellring_cfg_check
    import cellring_pkg::*;
(
    input  logic [PTR_W-1:0] start_ptr,
    input  logic [PTR_W-1:0] end_ptr,
    input  logic [1:0]       frame_sel,
    output logic             bad_mult,
    output logic             bad_align,
    output logic             bad_min,
    output logic [LEN_W-1:0] len_bytes
);
    logic [PTR_W-1:0] unit_m;
    logic [PTR_W-1:0] mask;
    logic [PTR_W-1:0] len_units;
    logic [PTR_W:0]   min_units;

    always_comb begin
        unit_m    = frame_units(frame_sel);
        mask      = unit_m - 1'b1;
        len_units = (end_ptr > start_ptr) ? (end_ptr - start_ptr) : '0;
        min_units = {unit_m, 1'b0};
        bad_mult  = |(len_units & mask);
        bad_align = |(start_ptr & mask);
        bad_min   = ({1'b0, len_units} < min_units);
        len_bytes = {len_units, {LOW_W{1'b0}}};
    end
endmodule

// File: rtl/cellring_zero_fill.sv
module cellring_zero_fill
    import cellring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [BASE_W-1:0] base,
    input  logic [PTR_W-1:0]  start_ptr,
    input  logic [PTR_W-1:0]  end_ptr,
    input  logic              mem_ready,
    output mem_wr_t           wr,
    output logic              last_acc,
    output logic              done
);
    localparam int WPTR_W = PTR_W + LOW_W - 2;

    logic              active;
    logic [WPTR_W-1:0] wptr;
    logic [WPTR_W-1:0] wlast;

    always_comb begin
        wlast    = {end_ptr, 2'b00} - 1'b1;
        wr.req   = active;
        wr.addr  = {base, wptr, 2'b00};
        wr.data  = '0;
        last_acc = active && mem_ready && (wptr == wlast);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            wptr   <= '0;
            done   <= 1'b0;
        end else begin
            done <= last_acc;
            if (go) begin
                active <= 1'b1;
                wptr   <= {start_ptr, 2'b00};
            end else if (active && mem_ready) begin
                if (wptr == wlast) active <= 1'b0;
                else               wptr   <= wptr + 1'b1;
            end
        end
    end

    // R7
    fill_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr.req && mem_ready && !last_acc && !go) |=> (wr.addr == $past(wr.addr) + ADDR_W'(4)));

    // R8
    fill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/cellring_slot_writer.sv
module cellring_slot_writer
    import cellring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              clr,
    input  logic [BASE_W-1:0] base,
    input  logic [PTR_W-1:0]  start_ptr,
    input  logic [PTR_W-1:0]  end_ptr,
    input  logic              cell_valid,
    input  logic [DATA_W-1:0] cell_data,
    output logic              cell_ready,
    input  logic              mem_ready,
    output mem_wr_t           wr,
    output logic [ADDR_W-1:0] newest_addr,
    output logic              newest_valid
);
    logic [PTR_W-1:0]  slot_ptr;
    logic [WIDX_W-1:0] widx;
    logic [SEQ_W-1:0]  seq;
    logic              in_cell;
    logic              acc;
    logic              slot_end;
    logic [PTR_W:0]    next_ptr;

    always_comb begin
        in_cell    = (widx < WIDX_W'(CELL_WORDS));
        cell_ready = en && in_cell && mem_ready;
        wr.req     = en && (in_cell ? cell_valid : 1'b1);
        wr.addr    = byte_addr(base, slot_ptr) + ADDR_W'({widx, 2'b00});
        if (in_cell)
            wr.data = cell_data;
        else if (widx == WIDX_W'(CELL_WORDS))
            wr.data = {1'b1, {(DATA_W-1-SEQ_W){1'b0}}, seq};
        else
            wr.data = '0;
        acc      = wr.req && mem_ready;
        slot_end = acc && (widx == WIDX_W'(SLOT_WORDS - 1));
        next_ptr = {1'b0, slot_ptr} + (PTR_W+1)'(SLOT_UNITS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_ptr     <= '0;
            widx         <= '0;
            seq          <= '0;
            newest_addr  <= '0;
            newest_valid <= 1'b0;
        end else if (clr) begin
            slot_ptr     <= start_ptr;
            widx         <= '0;
            seq          <= '0;
            newest_valid <= 1'b0;
        end else if (acc) begin
            widx <= widx + 1'b1;
            if (slot_end) begin
                seq          <= seq + 1'b1;
                newest_addr  <= byte_addr(base, slot_ptr);
                newest_valid <= 1'b1;
                slot_ptr     <= (next_ptr >= {1'b0, end_ptr}) ? start_ptr : next_ptr[PTR_W-1:0];
            end
        end
    end

    // R11
    ring_bounds_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (slot_ptr >= start_ptr && slot_ptr < end_ptr));

    // R10
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_end && !clr) |=> (seq == $past(seq) + 1'b1));
endmodule

// File: rtl/cellring_buf_ctrl.sv
module cellring_buf_ctrl
    import cellring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [PTR_W-1:0]  cfg_start_ptr,
    input  logic [PTR_W-1:0]  cfg_end_ptr,
    input  logic [1:0]        cfg_frame_sel,
    input  logic              start_req,
    output logic              cfg_err,
    output logic [LEN_W-1:0]  len_bytes,
    output logic              fill_done,
    output logic              link_up,
    input  logic              cell_valid,
    input  logic [DATA_W-1:0] cell_data,
    output logic              cell_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] newest_slot_addr,
    output logic              newest_valid
);
    lnk_state_e state;
    logic       bad_mult, bad_align, bad_min;
    logic       go;
    logic       fill_last;
    mem_wr_t    fill_wr, slot_wr, mux_wr;

    cellring_cfg_check u_check (
        .start_ptr (cfg_start_ptr),
        .end_ptr   (cfg_end_ptr),
        .frame_sel (cfg_frame_sel),
        .bad_mult  (bad_mult),
        .bad_align (bad_align),
        .bad_min   (bad_min),
        .len_bytes (len_bytes)
    );

    assign cfg_err = bad_mult | bad_align | bad_min;
    assign go      = (state == LNK_IDLE) && start_req && !cfg_err;
    assign link_up = (state == LNK_RUN);

    cellring_zero_fill u_fill (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .base      (cfg_base),
        .start_ptr (cfg_start_ptr),
        .end_ptr   (cfg_end_ptr),
        .mem_ready (mem_ready),
        .wr        (fill_wr),
        .last_acc  (fill_last),
        .done      (fill_done)
    );

    cellring_slot_writer u_slot (
        .clk          (clk),
        .rst          (rst),
        .en           (link_up),
        .clr          (go),
        .base         (cfg_base),
        .start_ptr    (cfg_start_ptr),
        .end_ptr      (cfg_end_ptr),
        .cell_valid   (cell_valid),
        .cell_data    (cell_data),
        .cell_ready   (cell_ready),
        .mem_ready    (mem_ready),
        .wr           (slot_wr),
        .newest_addr  (newest_slot_addr),
        .newest_valid (newest_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LNK_IDLE;
        end else begin
            case (state)
                LNK_IDLE: if (go)        state <= LNK_FILL;
                LNK_FILL: if (fill_last) state <= LNK_RUN;
                default:                 state <= state;
            endcase
        end
    end

    always_comb begin
        case (state)
            LNK_FILL: mux_wr = fill_wr;
            LNK_RUN:  mux_wr = slot_wr;
            default:  mux_wr = '0;
        endcase
        mem_req   = mux_wr.req;
        mem_addr  = mux_wr.addr;
        mem_wdata = mux_wr.data;
    end

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == LNK_IDLE) |-> !mem_req);

    // R8
    down_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !link_up |-> !cell_ready);

    // R8
    up_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_up) |-> fill_done);
endmodule

// File: tb/cellring_buf_ctrl_tb.sv
module cellring_buf_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] cfg_base = 12'hABC;
    logic [15:0] cfg_start_ptr = 16'h0100;
    logic [15:0] cfg_end_ptr = 16'h0200;
    logic [1:0]  cfg_frame_sel = 2'd0;
    logic        start_req = 1'b0;
    logic        cfg_err;
    logic [19:0] len_bytes;
    logic        fill_done;
    logic        link_up;
    logic        cell_valid = 1'b0;
    logic [31:0] cell_data = '0;
    logic        cell_ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] newest_slot_addr;
    logic        newest_valid;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] exp_ptr;
    logic [15:0] exp_seq;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cellring_buf_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_start_ptr(cfg_start_ptr),
        .cfg_end_ptr(cfg_end_ptr), .cfg_frame_sel(cfg_frame_sel), .start_req(start_req),
        .cfg_err(cfg_err), .len_bytes(len_bytes), .fill_done(fill_done), .link_up(link_up),
        .cell_valid(cell_valid), .cell_data(cell_data), .cell_ready(cell_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .newest_slot_addr(newest_slot_addr), .newest_valid(newest_valid)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!link_up && !mem_req && !fill_done, "R8 reset link down", {link_up, mem_req, fill_done}, 0);
        check(!newest_valid && newest_slot_addr == 0, "R12 reset newest", newest_slot_addr, 0);
        check(!cfg_err, "R2 reset clean cfg", cfg_err, 0);
        check(len_bytes == 20'd4096, "R5 reset len", len_bytes, 4096);
    endtask

    task automatic t_cfg(input logic [1:0] sel, input logic [15:0] s, input logic [15:0] e,
                         input bit exp_err, input logic [19:0] exp_len, input string req);
        @(negedge clk);
        cfg_frame_sel = sel; cfg_start_ptr = s; cfg_end_ptr = e;
        #1;
        check(cfg_err == exp_err, req, cfg_err, exp_err);
        check(len_bytes == exp_len, "R5 len_bytes", len_bytes, exp_len);
    endtask

    task automatic t_cfg_checks();
        t_cfg(2'd0, 16'h0100, 16'h0240, 1'b1, 20'd5120, "R2 length not multiple");
        t_cfg(2'd0, 16'h0140, 16'h0240, 1'b1, 20'd4096, "R3 start misaligned");
        t_cfg(2'd0, 16'h0100, 16'h0180, 1'b1, 20'd2048, "R4 below minimum");
        t_cfg(2'd0, 16'h0200, 16'h0100, 1'b1, 20'd0,    "R4 end below start");
        t_cfg(2'd3, 16'h0400, 16'h0C00, 1'b0, 20'd32768, "R13 M=256 legal");
        t_cfg(2'd3, 16'h0400, 16'h0800, 1'b1, 20'd16384, "R13 M=256 too short");
        t_cfg(2'd1, 16'h0400, 16'h0800, 1'b0, 20'd16384, "R13 M=64 legal");
        t_cfg(2'd2, 16'h0400, 16'h0800, 1'b0, 20'd16384, "R13 M=128 legal");
        t_cfg(2'd2, 16'h0100, 16'h0500, 1'b1, 20'd16384, "R13 M=128 misaligned");
    endtask

    task automatic t_start_blocked();
        @(negedge clk);
        cfg_frame_sel = 2'd0; cfg_start_ptr = 16'h0140; cfg_end_ptr = 16'h0240;
        mem_ready = 1'b1; start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        for (int i = 0; i < 5; i++) begin
            #1;
            check(!mem_req && !link_up, "R6 start ignored on bad cfg", {mem_req, link_up}, 0);
            @(negedge clk);
        end
    endtask

    task automatic t_fill();
        logic [31:0] exp_a;
        int acc;
        int guard;
        cfg_frame_sel = 2'd0; cfg_start_ptr = 16'h0100; cfg_end_ptr = 16'h0200;
        cell_valid = 1'b1; cell_data = 32'hDEAD_BEEF;
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        exp_a = {12'hABC, 16'h0100, 4'h0};
        acc = 0;
        guard = 0;
        while (acc < 1024 && guard < 4000) begin
            mem_ready = (guard % 3) != 2;
            #1;
            if (guard == 0)
                check(mem_addr == 32'hABC0_1000, "R1 first fill address", mem_addr, 32'hABC0_1000);
            check(mem_req && mem_addr == exp_a && mem_wdata == 0, "R7 zero fill word",
                  {mem_addr, mem_wdata}, {exp_a, 32'h0});
            check(!cell_ready && !link_up && !fill_done, "R8 no cells during fill",
                  {cell_ready, link_up, fill_done}, 0);
            if (mem_ready) begin
                acc++;
                exp_a = exp_a + 4;
            end
            guard++;
            @(negedge clk);
        end
        mem_ready = 1'b0; cell_valid = 1'b0;
        #1;
        check(fill_done && link_up, "R8 done pulse and link up", {fill_done, link_up}, 2'b11);
        check(!mem_req, "R8 no write without cell", mem_req, 0);
        @(negedge clk);
        #1;
        check(!fill_done && link_up, "R8 done is one cycle", {fill_done, link_up}, 2'b01);
        exp_ptr = 16'h0100;
        exp_seq = 16'h0;
    endtask

    task automatic t_cell(input bit stall);
        logic [31:0] slot_a;
        logic [31:0] exp_d;
        slot_a = {12'hABC, exp_ptr, 4'h0};
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            cell_valid = (k < 13);
            cell_data = {exp_seq, 8'hC5, 8'(k)};
            if (stall && (k == 0 || k == 14)) begin
                mem_ready = 1'b0;
                #1;
                check(!cell_ready, "R9 no accept while memory busy", cell_ready, 0);
                check(mem_addr == slot_a + 32'(k * 4), "R7 address holds on stall", mem_addr, slot_a + 32'(k * 4));
                @(negedge clk);
            end
            mem_ready = 1'b1;
            #1;
            if (k < 13) begin
                exp_d = {exp_seq, 8'hC5, 8'(k)};
                check(cell_ready == 1'b1, "R9 cell word ready", cell_ready, 1);
            end else begin
                exp_d = (k == 13) ? {1'b1, 15'h0, exp_seq} : 32'h0;
                check(cell_ready == 1'b0, "R10 trailer needs no input", cell_ready, 0);
            end
            check(mem_req && mem_addr == slot_a + 32'(k * 4), "R11 slot word address",
                  mem_addr, slot_a + 32'(k * 4));
            check(mem_wdata == exp_d, (k < 13) ? "R9 cell word data" : "R10 trailer data", mem_wdata, exp_d);
        end
        @(negedge clk);
        cell_valid = 1'b0; mem_ready = 1'b0;
        #1;
        check(newest_valid && newest_slot_addr == slot_a, "R12 newest slot", newest_slot_addr, slot_a);
        exp_seq = exp_seq + 1;
        exp_ptr = exp_ptr + 16'd4;
        if (exp_ptr >= 16'h0200) exp_ptr = 16'h0100;
    endtask

    initial begin
        t_reset();
        t_cfg_checks();
        t_start_blocked();
        t_fill();
        for (int c = 0; c < 65; c++) t_cell(c < 3 || c == 64);
        check(exp_ptr == 16'h0104, "R11 wrapped to start", exp_ptr, 16'h0104);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #600000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule